// File: doc/BRIEF.md
# Polled Two-Port Sensor Read Sequencer

This block sits on the host side of a hardware-monitoring controller that is reached through two byte-wide ports, a data port and a command port. A client hands it a 16-bit sensor address over a ready/valid request channel. The block then drives the port bus through a fixed handshake. It writes a value, polls until a specific byte comes back, writes again and polls again. It then fetches the result byte and returns the controller to its idle condition with a resynchronisation loop.

Each wait is bounded by a parameterised number of attempts, so a silent or confused controller cannot stall the host. On completion the block pulses a done flag with the result byte. When a wait runs out, it returns zero and sets a sticky error flag that stays up until the next request is taken. The port bus is minimal: a one-bit port select, separate read and write strobes, and read data that is valid in the cycle after the read strobe.

Top module: `sensor_poll_seq`

## Requirements
- R1: After a request is accepted, the first bus operation is a write of address bits 15:8 (bank) to the data port (port_sel = 0). The sensor index (address bits 7:0) is later written to the command port (port_sel = 1).
- R2: After the bank write, the data port is read repeatedly until it returns 0x08. Each mismatching read is followed by another read of the data port.
- R3: Once 0x08 is seen, the sensor index is written to the command port, and the data port is then polled until it returns 0x01.
- R4: After 0x01 is seen, one read of the command port supplies the result byte. That byte is reported on rsp_data with rsp_err = 0 once the resynchronisation loop ends successfully.
- R5: Resynchronisation reads the data port. On 0x08 the operation ends. Otherwise the block writes 0x00 to the data port, polls the data port for 0x09, polls the command port for 0xAC, and starts a new pass with a fresh data-port read.
- R6: Any poll fails on its TRY_LIMIT-th mismatching read. The resynchronisation loop fails when its TRY_LIMIT-th data-port read is not 0x08. A failure ends the operation at once, with rsp_done, rsp_err = 1 and rsp_data = 0x00, and no further bus operations follow.
- R7: rsp_err is sticky. It stays set through idle cycles and is cleared in the cycle after the next request is accepted.
- R8: req_ready is high only while idle. A request presented while an operation is running is ignored. No bus operations occur while idle.
- R9: At most one of port_rd and port_wr is high in any cycle. Read data on port_rdata is taken in the cycle after the read strobe.
- R10: rsp_done is a single-cycle pulse. It coincides with req_ready returning high, in the cycle after the final check.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_addr | input | 16 | Sensor address: bank in 15:8, sensor index in 7:0 |
| port_sel | output | 1 | Port select: 0 data port, 1 command port |
| port_rd | output | 1 | Read strobe |
| port_wr | output | 1 | Write strobe |
| port_wdata | output | 8 | Write data |
| port_rdata | input | 8 | Read data, valid the cycle after port_rd |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_data | output | 8 | Result byte, zero after a failure |
| rsp_err | output | 1 | Sticky timeout error |

## Verification
A wrong sequencer state shows up on the port bus within one or two cycles, as an out-of-order strobe, a wrong port select or a wrong write byte. The bench compares every strobe against an independently built sequence of expected operations, so such a fault is caught at the first bad cycle. A wrong retry counter shows up as a failure that comes one attempt early or late. That leaves an extra or missing read in the operation stream and a wrong rsp_err at the done pulse. A wrong latched result shows up only at the done pulse, at the end of resynchronisation.

// File: rtl/sps_pkg.sv
`timescale 1ns/1ps
package sps_pkg;

    localparam logic [7:0] ACK_BANK  = 8'h08;
    localparam logic [7:0] ACK_SENS  = 8'h01;
    localparam logic [7:0] ACK_CLR   = 8'h09;
    localparam logic [7:0] ACK_CMD   = 8'hAC;
    localparam logic [7:0] CLR_BYTE  = 8'h00;
    localparam logic       SEL_DATA  = 1'b0;
    localparam logic       SEL_CMD   = 1'b1;

    typedef enum logic [3:0] {
        S_IDLE,
        S_WR_BANK,
        S_RD_BANK,
        S_CK_BANK,
        S_WR_SENS,
        S_RD_SENS,
        S_CK_SENS,
        S_RD_RES,
        S_CAP_RES,
        S_RS_RD,
        S_RS_CK,
        S_RS_WR,
        S_RS_RD9,
        S_RS_CK9,
        S_RS_RDAC,
        S_RS_CKAC
    } seq_state_e;

endpackage

// File: rtl/sps_try_cnt.sv
`timescale 1ns/1ps
module sps_try_cnt #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last = (cnt_q == CW'(LIMIT - 1));

    // R6: the sequencer never asks for a clear and a step together
    a_r6_no_clr_inc: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr && inc));

    // R6: a step is never requested once the final attempt is reached
    a_r6_no_inc_past_last: assert property (@(posedge clk) disable iff (!rst_n)
        last |-> !inc);

endmodule

// File: rtl/sensor_poll_seq.sv
`timescale 1ns/1ps
module sensor_poll_seq
    import sps_pkg::*;
#(
    parameter int TRY_LIMIT = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [15:0] req_addr,
    output logic        port_sel,
    output logic        port_rd,
    output logic        port_wr,
    output logic [7:0]  port_wdata,
    input  logic [7:0]  port_rdata,
    output logic        rsp_done,
    output logic [7:0]  rsp_data,
    output logic        rsp_err
);

    typedef struct packed {
        seq_state_e  state;
        logic [7:0]  bank;
        logic [7:0]  sens;
        logic [7:0]  data;
        logic        err;
        logic        done;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic in_clr, in_inc, in_last;
    logic out_clr, out_inc, out_last;
    logic fail;

    sps_try_cnt #(.LIMIT(TRY_LIMIT)) u_poll_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (in_clr),
        .inc  (in_inc),
        .last (in_last)
    );

    sps_try_cnt #(.LIMIT(TRY_LIMIT)) u_pass_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (out_clr),
        .inc  (out_inc),
        .last (out_last)
    );

    always_comb begin
        r_d        = r_q;
        r_d.done   = 1'b0;
        port_rd    = 1'b0;
        port_wr    = 1'b0;
        port_sel   = SEL_DATA;
        port_wdata = '0;
        in_clr     = 1'b0;
        in_inc     = 1'b0;
        out_clr    = 1'b0;
        out_inc    = 1'b0;
        fail       = 1'b0;

        case (r_q.state)
            S_IDLE: begin
                if (req_valid) begin
                    r_d.bank  = req_addr[15:8];
                    r_d.sens  = req_addr[7:0];
                    r_d.err   = 1'b0;
                    in_clr    = 1'b1;
                    r_d.state = S_WR_BANK;
                end
            end
            S_WR_BANK: begin
                port_wr    = 1'b1;
                port_wdata = r_q.bank;
                r_d.state  = S_RD_BANK;
            end
            S_RD_BANK: begin
                port_rd   = 1'b1;
                r_d.state = S_CK_BANK;
            end
            S_CK_BANK: begin
                if (port_rdata == ACK_BANK) begin
                    in_clr    = 1'b1;
                    r_d.state = S_WR_SENS;
                end else if (in_last) begin
                    fail = 1'b1;
                end else begin
                    in_inc    = 1'b1;
                    r_d.state = S_RD_BANK;
                end
            end
            S_WR_SENS: begin
                port_wr    = 1'b1;
                port_sel   = SEL_CMD;
                port_wdata = r_q.sens;
                r_d.state  = S_RD_SENS;
            end
            S_RD_SENS: begin
                port_rd   = 1'b1;
                r_d.state = S_CK_SENS;
            end
            S_CK_SENS: begin
                if (port_rdata == ACK_SENS) begin
                    in_clr    = 1'b1;
                    r_d.state = S_RD_RES;
                end else if (in_last) begin
                    fail = 1'b1;
                end else begin
                    in_inc    = 1'b1;
                    r_d.state = S_RD_SENS;
                end
            end
            S_RD_RES: begin
                port_rd   = 1'b1;
                port_sel  = SEL_CMD;
                r_d.state = S_CAP_RES;
            end
            S_CAP_RES: begin
                r_d.data  = port_rdata;
                out_clr   = 1'b1;
                r_d.state = S_RS_RD;
            end
            S_RS_RD: begin
                port_rd   = 1'b1;
                r_d.state = S_RS_CK;
            end
            S_RS_CK: begin
                if (port_rdata == ACK_BANK) begin
                    r_d.done  = 1'b1;
                    r_d.state = S_IDLE;
                end else if (out_last) begin
                    fail = 1'b1;
                end else begin
                    out_inc   = 1'b1;
                    in_clr    = 1'b1;
                    r_d.state = S_RS_WR;
                end
            end
            S_RS_WR: begin
                port_wr    = 1'b1;
                port_wdata = CLR_BYTE;
                r_d.state  = S_RS_RD9;
            end
            S_RS_RD9: begin
                port_rd   = 1'b1;
                r_d.state = S_RS_CK9;
            end
            S_RS_CK9: begin
                if (port_rdata == ACK_CLR) begin
                    in_clr    = 1'b1;
                    r_d.state = S_RS_RDAC;
                end else if (in_last) begin
                    fail = 1'b1;
                end else begin
                    in_inc    = 1'b1;
                    r_d.state = S_RS_RD9;
                end
            end
            S_RS_RDAC: begin
                port_rd   = 1'b1;
                port_sel  = SEL_CMD;
                r_d.state = S_RS_CKAC;
            end
            S_RS_CKAC: begin
                if (port_rdata == ACK_CMD) begin
                    in_clr    = 1'b1;
                    r_d.state = S_RS_RD;
                end else if (in_last) begin
                    fail = 1'b1;
                end else begin
                    in_inc    = 1'b1;
                    r_d.state = S_RS_RDAC;
                end
            end
            default: r_d.state = S_IDLE;
        endcase

        if (fail) begin
            r_d.done  = 1'b1;
            r_d.err   = 1'b1;
            r_d.data  = '0;
            r_d.state = S_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: S_IDLE, bank: '0, sens: '0, data: '0, err: 1'b0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.state == S_IDLE);
    assign rsp_done  = r_q.done;
    assign rsp_data  = r_q.data;
    assign rsp_err   = r_q.err;

    // R9: never read and write the port bus in the same cycle
    a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(port_rd && port_wr));

    // R8: the bus is quiet whenever a request could be taken
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !(port_rd || port_wr));

    // R1: the first operation after acceptance writes the bank to the data port
    a_r1_bank_first: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (port_wr && !port_sel && port_wdata == $past(req_addr[15:8])));

    // R7: acceptance clears the sticky error
    a_r7_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !rsp_err);

    // R6: a failed operation returns zero
    a_r6_zero_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && rsp_err) |-> (rsp_data == 8'h00));

    // R10: done is a single-cycle pulse that coincides with ready
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    a_r10_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> req_ready);

endmodule

// File: tb/sensor_poll_seq_tb_top.sv
`timescale 1ns/1ps
module sensor_poll_seq_tb_top;

    localparam int L = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_addr = '0;
    logic        port_sel, port_rd, port_wr;
    logic [7:0]  port_wdata;
    logic [7:0]  port_rdata = 8'h00;
    logic        rsp_done;
    logic [7:0]  rsp_data;
    logic        rsp_err;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit ended  = 1'b0;

    typedef struct {
        bit         wr;
        bit         sel;
        logic [7:0] d;
    } op_t;

    op_t        expq[$];
    logic [7:0] rdq[$];

    always #2.5 clk = ~clk;

    sensor_poll_seq #(.TRY_LIMIT(L)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .port_sel  (port_sel),
        .port_rd   (port_rd),
        .port_wr   (port_wr),
        .port_wdata(port_wdata),
        .port_rdata(port_rdata),
        .rsp_done  (rsp_done),
        .rsp_data  (rsp_data),
        .rsp_err   (rsp_err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Reference model of the bus: every strobe is compared to the expected operation stream
    always @(negedge clk) begin
        if (rst_n) begin
            if (port_rd && port_wr)
                check(1'b0, "R9 both strobes", 3, 1);
            if (port_rd || port_wr) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R8/R6 unexpected bus op", {port_wr, port_sel}, 0);
                end else begin
                    op_t e;
                    e = expq.pop_front();
                    check(e.wr == port_wr && e.sel == port_sel && (!e.wr || e.d == port_wdata),
                          "R9 bus op (R1/R2/R3/R5 order)",
                          {port_wr, port_sel, port_wdata}, {e.wr, e.sel, e.d});
                end
                if (port_rd)
                    port_rdata <= (rdq.size() != 0) ? rdq.pop_front() : 8'hEE;
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            finish_run();
        end
    end

    function automatic bit add_poll(input bit sel, input logic [7:0] good, input int n);
        for (int i = 0; i < n && i < L; i++) begin
            expq.push_back('{wr: 1'b0, sel: sel, d: 8'h00});
            rdq.push_back(8'h3C);
        end
        if (n >= L) return 1'b1;
        expq.push_back('{wr: 1'b0, sel: sel, d: 8'h00});
        rdq.push_back(good);
        return 1'b0;
    endfunction

    // n8/n1/n9/nac: mismatching reads before the wanted byte; npass: resync passes
    function automatic bit build(input logic [15:0] addr, input int n8, input int n1,
                                 input logic [7:0] res, input int npass,
                                 input int n9, input int nac);
        expq.push_back('{wr: 1'b1, sel: 1'b0, d: addr[15:8]});
        if (add_poll(1'b0, 8'h08, n8)) return 1'b1;
        expq.push_back('{wr: 1'b1, sel: 1'b1, d: addr[7:0]});
        if (add_poll(1'b0, 8'h01, n1)) return 1'b1;
        expq.push_back('{wr: 1'b0, sel: 1'b1, d: 8'h00});
        rdq.push_back(res);
        for (int p = 0; p < L; p++) begin
            expq.push_back('{wr: 1'b0, sel: 1'b0, d: 8'h00});
            if (p >= npass) begin
                rdq.push_back(8'h08);
                return 1'b0;
            end
            rdq.push_back(8'h55);
            if (p == L - 1) return 1'b1;
            expq.push_back('{wr: 1'b1, sel: 1'b0, d: 8'h00});
            if (add_poll(1'b0, 8'h09, n9)) return 1'b1;
            if (add_poll(1'b1, 8'hAC, nac)) return 1'b1;
        end
        return 1'b1;
    endfunction

    task automatic run_txn(input string tag, input logic [15:0] addr, input int n8, input int n1,
                           input logic [7:0] res, input int npass, input int n9, input int nac,
                           input bit hold_busy);
        bit efail;
        logic [7:0] edata;
        int n;
        efail = build(addr, n8, n1, res, npass, n9, nac);
        edata = efail ? 8'h00 : res;
        n = 0;
        while (!req_ready && n < 5000) begin @(negedge clk); n++; end
        req_valid = 1'b1;
        req_addr  = addr;
        @(negedge clk);
        check(rsp_err == 1'b0, {tag, " R7 err cleared after accept"}, rsp_err, 0);
        check(req_ready == 1'b0, {tag, " R8 busy"}, req_ready, 0);
        if (hold_busy) req_addr = 16'hFFFF;
        else req_valid = 1'b0;
        n = 0;
        while (!rsp_done && n < 5000) begin @(negedge clk); n++; end
        req_valid = 1'b0;
        check(rsp_done == 1'b1, {tag, " R10 done seen"}, rsp_done, 1);
        check(req_ready == 1'b1, {tag, " R10 ready with done"}, req_ready, 1);
        check(rsp_err == efail, {tag, " R6 error flag"}, rsp_err, efail);
        check(rsp_data == edata, {tag, " R4 result byte"}, rsp_data, edata);
        @(negedge clk);
        check(rsp_done == 1'b0, {tag, " R10 done pulse width"}, rsp_done, 0);
        repeat (3) @(negedge clk);
        check(expq.size() == 0, {tag, " R6 operation stream complete"}, expq.size(), 0);
        check(rsp_err == efail, {tag, " R7 error held"}, rsp_err, efail);
        expq.delete();
        rdq.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R8 reset ready", req_ready, 1);
        check(rsp_done == 1'b0, "R10 reset done", rsp_done, 0);
        check(rsp_err == 1'b0, "R7 reset err", rsp_err, 0);
        check(!port_rd && !port_wr, "R8 reset bus quiet", {port_rd, port_wr}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_txn("R1 direct",             16'h1234, 0, 0, 8'h5A, 0, 0, 0, 1'b0);
        run_txn("R2 R3 R5 stalls",       16'h0203, 2, 3, 8'hC3, 1, 1, 2, 1'b0);
        run_txn("R2 R5 at limit",        16'hA5F0, L-1, L-1, 8'h7E, L-1, L-1, L-1, 1'b0);
        run_txn("R6 bank poll timeout",  16'h0911, L, 0, 8'h42, 0, 0, 0, 1'b0);
        run_txn("R6 sensor poll timeout",16'h0A22, 0, L, 8'h42, 0, 0, 0, 1'b0);
        run_txn("R6 resync pass limit",  16'h0B33, 0, 0, 8'h99, L, 0, 0, 1'b0);
        run_txn("R5 R6 clear-ack timeout",16'h0C44, 1, 1, 8'h99, 1, L, 0, 1'b0);
        run_txn("R5 R6 cmd-ack timeout", 16'h0D55, 0, 0, 8'h99, 2, 0, L, 1'b0);
        run_txn("R8 request held busy",  16'h4321, 1, 0, 8'hE7, 1, 0, 1, 1'b1);
        run_txn("R4 after error",        16'hFF00, 0, 0, 8'h00, 0, 0, 0, 1'b0);
        run_txn("R4 full byte",          16'h00FF, 0, 1, 8'hFF, 0, 0, 0, 1'b0);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule